// File: doc/BRIEF.md
# Serial Flash Instruction Frame Sequencer

This block issues one serial-flash instruction frame at a time on a bidirectional bus of up to four data lines. A frame is a fixed sequence of phases. Each phase is switched on or off on its own: the opcode, the address of 24 or 32 bits, an optional mode byte, a number of turnaround (dummy) clocks and a 32-bit data word. The opcode phase has its own lane width. So does the data phase. The address and mode-byte phases share a third lane width. With this, one block can drive single-, dual- and quad-capable memories and mix widths within one frame.

A frame starts in one of two ways, chosen by a configuration bit. In command mode a start strobe issues a frame with any opcode, for example program, erase, lock or ID read. The frame uses the command address and the command write word. In memory mode the command path is shut off. Instead, a read request carrying a window offset turns into a flash read frame at that offset, so that instructions can be fetched straight from the flash. When continuous reading is enabled, every memory read after the first one leaves out the opcode phase.

The serial clock idles low. One serial clock takes two system clocks: a low half, during which the block changes its outputs, and a high half, at whose end the block samples the input lines.

Top module: `flashFrameSeq`

## Requirements
- R1: After reset, and whenever no frame is in progress, csN is 1, sck is 0, ioOe is 0 and busy is 0.
- R2: The opcode phase sends cfgOpcode MSB first in 8/W serial clocks, where W is the lane width from cfgInstLanes.
- R3: The address phase sends 24 bits (the low 24 of the address) when cfgAddr32 is 0, or all 32 bits when it is 1, MSB first, at the width from cfgAddrLanes.
- R4: When cfgOptEn is 1, cfgOptByte follows the address MSB first, at the address lane width.
- R5: The dummy phase lasts exactly cfgDummy serial clocks (0 to 15), with ioOe all zero.
- R6: The data phase moves 32 bits MSB first at the width from cfgDataLanes. On a read (cfgDataRead=1) ioOe is 0 and the first bit received becomes bit 31 of rdData. On a write, cmdWrData is sent.
- R7: Lane codes are 00 single, 01 dual, 10 quad, and 11, which acts as single. A driving phase enables ioOe = 0001 (single, on IO0), 0011 (dual, IO1:IO0) or 1111 (quad, IO3:IO0). The higher-numbered line carries the more significant bit. Single-lane read data is taken from IO1.
- R8: In memory mode, rdReq starts a read frame whose address is rdAddr zero-extended. Address and data phases are forced on and the data phase is forced to read. At frame end rdData holds the word and rdValid pulses for one cycle, together with frameDone.
- R9: cmdStart is ignored in memory mode, and rdReq is ignored in command mode: no frame starts.
- R10: When cfgContRead and cfgMemMode are 1, a memory read that follows a completed memory read omits the opcode phase. Clearing cfgContRead brings the opcode back on the next frame.
- R11: Disabled phases are skipped. The number of sck pulses in a frame equals the sum of the clocks of the enabled phases, and each sck high lasts one system clock.
- R12: A start request that arrives while busy is 1 is dropped and does not cause a later frame.
- R13: csN returns to 1 after the last serial clock of a frame. sck is 0 whenever csN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgMemMode | input | 1 | 1: memory-mapped read mode, 0: command mode |
| cfgOpcode | input | 8 | Opcode sent in the opcode phase |
| cfgInstEn | input | 1 | Enable the opcode phase |
| cfgInstLanes | input | 2 | Lane code of the opcode phase |
| cfgAddrEn | input | 1 | Enable the address phase (command frames) |
| cfgAddrLanes | input | 2 | Lane code of the address and mode-byte phases |
| cfgAddr32 | input | 1 | 1: 32-bit address, 0: 24-bit address |
| cfgOptEn | input | 1 | Enable the mode-byte phase |
| cfgOptByte | input | 8 | Mode byte value |
| cfgDummy | input | DUMMY_W | Dummy clock count |
| cfgDataEn | input | 1 | Enable the data phase (command frames) |
| cfgDataRead | input | 1 | Data phase direction for command frames, 1 = read |
| cfgDataLanes | input | 2 | Lane code of the data phase |
| cfgContRead | input | 1 | Continuous read: skip the opcode on later memory reads |
| cmdStart | input | 1 | Start a command frame |
| cmdAddr | input | 32 | Address of a command frame |
| cmdWrData | input | 32 | Write word of a command frame |
| rdReq | input | 1 | Memory window read request |
| rdAddr | input | WIN_AW | Window offset of the read |
| rdData | output | 32 | Last word read from the flash |
| rdValid | output | 1 | One-cycle strobe: memory read data ready |
| frameDone | output | 1 | One-cycle strobe at the end of any frame |
| busy | output | 1 | A frame is in progress |
| csN | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| ioOut | output | 4 | Values driven on IO3..IO0 |
| ioOe | output | 4 | Output enables of IO3..IO0 |
| ioIn | input | 4 | Values sampled from IO3..IO0 |

## Verification
The bench builds the block with WIN_AW = 26, so the window offset is wider than a 24-bit flash address. A memory read with 32-bit addressing then has to carry offset bits 24 and 25 onto the bus, and a command address with a nonzero top byte shows that 24-bit mode drops that byte. DUMMY_W keeps its default of 4, which lets a frame use the largest count of 15 dummy clocks. The frames mix lane widths within a single frame to show that each phase follows its own lane code.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;

  typedef enum logic [1:0] {
    LANE_X1  = 2'b00,
    LANE_X2  = 2'b01,
    LANE_X4  = 2'b10,
    LANE_RSV = 2'b11
  } lane_e;

  // Order of the values is the order of the phases on the bus.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_INST  = 3'd1,
    PH_ADDR  = 3'd2,
    PH_OPT   = 3'd3,
    PH_DUMMY = 3'd4,
    PH_DATA  = 3'd5
  } phase_e;

  typedef struct packed {
    logic   startCmd;   // command frame accepted this cycle
    logic   startMem;   // memory read frame accepted this cycle
    logic   load;       // load the shifter for loadPhase
    phase_e loadPhase;
    logic   shift;      // end of an sck high half
    lane_e  lanes;      // lane mode of the current phase
    logic   drive;      // current phase drives the IO lines
    logic   capture;    // last edge of a read data phase
  } seqStrobe_t;

  // log2 of the lane width; the reserved code acts as single
  function automatic logic [1:0] laneShift(input lane_e l);
    case (l)
      LANE_X2: laneShift = 2'd1;
      LANE_X4: laneShift = 2'd2;
      default: laneShift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/flashSeqCtrl.sv
module flashSeqCtrl
  import flashSeqPkg::*;
#(
  parameter int DUMMY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdStart,
  input  logic               rdReq,
  input  logic               cfgMemMode,
  input  logic               cfgInstEn,
  input  logic [1:0]         cfgInstLanes,
  input  logic               cfgAddrEn,
  input  logic [1:0]         cfgAddrLanes,
  input  logic               cfgAddr32,
  input  logic               cfgOptEn,
  input  logic [DUMMY_W-1:0] cfgDummy,
  input  logic               cfgDataEn,
  input  logic               cfgDataRead,
  input  logic [1:0]         cfgDataLanes,
  input  logic               cfgContRead,
  output seqStrobe_t         strobe,
  output logic               csN,
  output logic               sck,
  output logic               busy,
  output logic               frameDone,
  output logic               rdValid
);

  localparam int CNT_W = (DUMMY_W > 6) ? DUMMY_W : 6;

  phase_e           state, nxtPhase;
  logic             sckHigh;
  logic [CNT_W-1:0] cnt;
  logic [5:1]       enLat, enStart, enCur;
  logic             rdLat, memLat, contActive;
  logic             idle, startCmd, startMem, startAny, lastEdge;
  logic [CNT_W-1:0] clkInst, clkAddr, clkOpt, clkDummy, clkData, nxtClocks;
  lane_e            instL, addrL, dataL, curLanes;

  assign instL = lane_e'(cfgInstLanes);
  assign addrL = lane_e'(cfgAddrLanes);
  assign dataL = lane_e'(cfgDataLanes);

  assign idle     = (state == PH_IDLE);
  assign startCmd = idle && cmdStart && !cfgMemMode;
  assign startMem = idle && rdReq && cfgMemMode;
  assign startAny = startCmd || startMem;
  assign lastEdge = !idle && sckHigh && (cnt == '0);

  // Phase enables for a frame being accepted now
  always_comb begin
    enStart[1] = cfgInstEn && !(startMem && contActive);
    enStart[2] = startMem ? 1'b1 : cfgAddrEn;
    enStart[3] = cfgOptEn;
    enStart[4] = (cfgDummy != '0);
    enStart[5] = startMem ? 1'b1 : cfgDataEn;
  end

  assign enCur = idle ? enStart : enLat;

  // Serial clocks per phase
  assign clkInst  = CNT_W'(6'd8 >> laneShift(instL));
  assign clkAddr  = CNT_W'((cfgAddr32 ? 6'd32 : 6'd24) >> laneShift(addrL));
  assign clkOpt   = CNT_W'(6'd8 >> laneShift(addrL));
  assign clkDummy = CNT_W'(cfgDummy);
  assign clkData  = CNT_W'(6'd32 >> laneShift(dataL));

  // First enabled phase after the current one
  always_comb begin
    nxtPhase = PH_IDLE;
    for (int i = 5; i >= 1; i--) begin
      if (enCur[i] && (i > int'(state))) nxtPhase = phase_e'(3'(i));
    end
  end

  always_comb begin
    case (nxtPhase)
      PH_INST:  nxtClocks = clkInst;
      PH_ADDR:  nxtClocks = clkAddr;
      PH_OPT:   nxtClocks = clkOpt;
      PH_DUMMY: nxtClocks = clkDummy;
      PH_DATA:  nxtClocks = clkData;
      default:  nxtClocks = '0;
    endcase
  end

  always_comb begin
    case (state)
      PH_INST:         curLanes = instL;
      PH_ADDR, PH_OPT: curLanes = addrL;
      PH_DATA:         curLanes = dataL;
      default:         curLanes = LANE_X1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= PH_IDLE;
      sckHigh    <= 1'b0;
      cnt        <= '0;
      enLat      <= '0;
      rdLat      <= 1'b0;
      memLat     <= 1'b0;
      contActive <= 1'b0;
      frameDone  <= 1'b0;
      rdValid    <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      rdValid   <= 1'b0;
      if (!cfgContRead || !cfgMemMode) contActive <= 1'b0;
      if (idle) begin
        if (startAny) begin
          enLat  <= enStart;
          rdLat  <= startMem ? 1'b1 : cfgDataRead;
          memLat <= startMem;
          if (nxtPhase == PH_IDLE) begin
            frameDone <= 1'b1;
          end else begin
            state   <= nxtPhase;
            cnt     <= nxtClocks - CNT_W'(1);
            sckHigh <= 1'b0;
          end
        end
      end else if (!sckHigh) begin
        sckHigh <= 1'b1;
      end else begin
        sckHigh <= 1'b0;
        if (cnt == '0) begin
          if (nxtPhase == PH_IDLE) begin
            state     <= PH_IDLE;
            frameDone <= 1'b1;
            rdValid   <= memLat;
            if (memLat && cfgContRead && cfgMemMode) contActive <= 1'b1;
          end else begin
            state <= nxtPhase;
            cnt   <= nxtClocks - CNT_W'(1);
          end
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    strobe.startCmd  = startCmd;
    strobe.startMem  = startMem;
    strobe.load      = (nxtPhase != PH_IDLE) && ((idle && startAny) || lastEdge);
    strobe.loadPhase = nxtPhase;
    strobe.shift     = !idle && sckHigh;
    strobe.lanes     = curLanes;
    strobe.drive     = (state == PH_INST) || (state == PH_ADDR) || (state == PH_OPT) ||
                       ((state == PH_DATA) && !rdLat);
    strobe.capture   = lastEdge && (state == PH_DATA) && rdLat;
  end

  assign csN  = idle;
  assign sck  = sckHigh;
  assign busy = !idle;

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid)
    else $error("rdValid longer than one cycle");

  assert_sck_half_R11: assert property (@(posedge clk) disable iff (!rstN)
    sckHigh |=> !sckHigh)
    else $error("sck high for more than one cycle");

  assert_cmd_ignored_mem_R9: assert property (@(posedge clk) disable iff (!rstN)
    (idle && cfgMemMode && cmdStart && !rdReq) |=> (state == PH_IDLE))
    else $error("command accepted in memory mode");

endmodule

// File: rtl/flashSeqData.sv
module flashSeqData
  import flashSeqPkg::*;
#(
  parameter int WIN_AW = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [7:0]        cfgOpcode,
  input  logic [7:0]        cfgOptByte,
  input  logic              cfgAddr32,
  input  logic [31:0]       cmdAddr,
  input  logic [31:0]       cmdWrData,
  input  logic [WIN_AW-1:0] rdAddr,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic [31:0]       rdData
);

  localparam int IO_W = 4;
  localparam int SH_W = 32;

  logic [SH_W-1:0] addrLat, wrLat, addrSrc, wrSrc, loadVal;
  logic [SH_W-1:0] outShift, outNext, inShift, inNext, rdReg;
  logic [1:0]      wsh;
  logic [2:0]      laneWidth;

  assign addrSrc = strobe.startMem ? SH_W'(rdAddr) :
                   strobe.startCmd ? cmdAddr : addrLat;
  assign wrSrc   = strobe.startCmd ? cmdWrData : wrLat;

  always_comb begin
    case (strobe.loadPhase)
      PH_INST: loadVal = {cfgOpcode, 24'h0};
      PH_ADDR: loadVal = cfgAddr32 ? addrSrc : {addrSrc[23:0], 8'h00};
      PH_OPT:  loadVal = {cfgOptByte, 24'h0};
      PH_DATA: loadVal = wrSrc;
      default: loadVal = '0;
    endcase
  end

  assign wsh       = laneShift(strobe.lanes);
  assign laneWidth = 3'd1 << wsh;

  always_comb begin
    case (wsh)
      2'd1:    begin outNext = outShift << 2; inNext = {inShift[SH_W-3:0], ioIn[1:0]}; end
      2'd2:    begin outNext = outShift << 4; inNext = {inShift[SH_W-5:0], ioIn}; end
      default: begin outNext = outShift << 1; inNext = {inShift[SH_W-2:0], ioIn[1]}; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLat  <= '0;
      wrLat    <= '0;
      outShift <= '0;
      inShift  <= '0;
      rdReg    <= '0;
    end else begin
      if (strobe.startCmd || strobe.startMem) begin
        addrLat <= addrSrc;
        wrLat   <= wrSrc;
      end
      if (strobe.load)       outShift <= loadVal;
      else if (strobe.shift) outShift <= outNext;
      if (strobe.shift)   inShift <= inNext;
      if (strobe.capture) rdReg   <= inNext;
    end
  end

  // Lane g carries shifter bit (SH_W - width + g) when it is in use
  for (genvar g = 0; g < IO_W; g++) begin : gLane
    logic       used;
    logic [5:0] bitIdx;
    assign used     = (3'(g) < laneWidth);
    assign bitIdx   = 6'(SH_W) - 6'(laneWidth) + 6'(g);
    assign ioOe[g]  = strobe.drive && used;
    assign ioOut[g] = used && outShift[bitIdx[4:0]];
  end

  assign rdData = rdReg;

  assert_oe_pattern_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == 4'b0000) || (ioOe == 4'b0001) || (ioOe == 4'b0011) || (ioOe == 4'b1111))
    else $error("illegal output enable pattern");

  assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> (ioOe == 4'b0000))
    else $error("IO driven during read data");

endmodule

// File: rtl/flashFrameSeq.sv
module flashFrameSeq
  import flashSeqPkg::*;
#(
  parameter int WIN_AW  = 24,
  parameter int DUMMY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgMemMode,
  input  logic [7:0]         cfgOpcode,
  input  logic               cfgInstEn,
  input  logic [1:0]         cfgInstLanes,
  input  logic               cfgAddrEn,
  input  logic [1:0]         cfgAddrLanes,
  input  logic               cfgAddr32,
  input  logic               cfgOptEn,
  input  logic [7:0]         cfgOptByte,
  input  logic [DUMMY_W-1:0] cfgDummy,
  input  logic               cfgDataEn,
  input  logic               cfgDataRead,
  input  logic [1:0]         cfgDataLanes,
  input  logic               cfgContRead,
  input  logic               cmdStart,
  input  logic [31:0]        cmdAddr,
  input  logic [31:0]        cmdWrData,
  input  logic               rdReq,
  input  logic [WIN_AW-1:0]  rdAddr,
  output logic [31:0]        rdData,
  output logic               rdValid,
  output logic               frameDone,
  output logic               busy,
  output logic               csN,
  output logic               sck,
  output logic [3:0]         ioOut,
  output logic [3:0]         ioOe,
  input  logic [3:0]         ioIn
);

  seqStrobe_t strobe;

  flashSeqCtrl #(.DUMMY_W(DUMMY_W)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdStart     (cmdStart),
    .rdReq        (rdReq),
    .cfgMemMode   (cfgMemMode),
    .cfgInstEn    (cfgInstEn),
    .cfgInstLanes (cfgInstLanes),
    .cfgAddrEn    (cfgAddrEn),
    .cfgAddrLanes (cfgAddrLanes),
    .cfgAddr32    (cfgAddr32),
    .cfgOptEn     (cfgOptEn),
    .cfgDummy     (cfgDummy),
    .cfgDataEn    (cfgDataEn),
    .cfgDataRead  (cfgDataRead),
    .cfgDataLanes (cfgDataLanes),
    .cfgContRead  (cfgContRead),
    .strobe       (strobe),
    .csN          (csN),
    .sck          (sck),
    .busy         (busy),
    .frameDone    (frameDone),
    .rdValid      (rdValid)
  );

  flashSeqData #(.WIN_AW(WIN_AW)) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgOpcode  (cfgOpcode),
    .cfgOptByte (cfgOptByte),
    .cfgAddr32  (cfgAddr32),
    .cmdAddr    (cmdAddr),
    .cmdWrData  (cmdWrData),
    .rdAddr     (rdAddr),
    .ioIn       (ioIn),
    .ioOut      (ioOut),
    .ioOe       (ioOe),
    .rdData     (rdData)
  );

  assert_idle_clock_low_R13: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck)
    else $error("sck high while deselected");

  assert_no_drive_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (ioOe == 4'b0000))
    else $error("IO driven while deselected");

endmodule

// File: tb/test_flashFrameSeq.sv
module test_flashFrameSeq;

  localparam int WIN_AW = 26;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgMemMode = 0, cfgInstEn = 0, cfgAddrEn = 0, cfgAddr32 = 0;
  logic        cfgOptEn = 0, cfgDataEn = 0, cfgDataRead = 0, cfgContRead = 0;
  logic [7:0]  cfgOpcode = 0, cfgOptByte = 0;
  logic [1:0]  cfgInstLanes = 0, cfgAddrLanes = 0, cfgDataLanes = 0;
  logic [3:0]  cfgDummy = 0;
  logic        cmdStart = 0, rdReq = 0;
  logic [31:0] cmdAddr = 0, cmdWrData = 0;
  logic [WIN_AW-1:0] rdAddr = 0;
  logic [31:0] rdData;
  logic        rdValid, frameDone, busy, csN, sck;
  logic [3:0]  ioOut, ioOe;
  logic [3:0]  ioIn;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flashFrameSeq #(.WIN_AW(WIN_AW), .DUMMY_W(4)) i_flashFrameSeq (
    .clk(clk), .rstN(rstN), .cfgMemMode(cfgMemMode), .cfgOpcode(cfgOpcode),
    .cfgInstEn(cfgInstEn), .cfgInstLanes(cfgInstLanes), .cfgAddrEn(cfgAddrEn),
    .cfgAddrLanes(cfgAddrLanes), .cfgAddr32(cfgAddr32), .cfgOptEn(cfgOptEn),
    .cfgOptByte(cfgOptByte), .cfgDummy(cfgDummy), .cfgDataEn(cfgDataEn),
    .cfgDataRead(cfgDataRead), .cfgDataLanes(cfgDataLanes), .cfgContRead(cfgContRead),
    .cmdStart(cmdStart), .cmdAddr(cmdAddr), .cmdWrData(cmdWrData), .rdReq(rdReq),
    .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid), .frameDone(frameDone),
    .busy(busy), .csN(csN), .sck(sck), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn)
  );

  // Flash side model: records every serial clock, feeds read data
  logic [3:0] capOut [0:127];
  logic [3:0] capOe  [0:127];
  logic [3:0] supply [0:127];
  int  capCnt = 0;
  int  frameStarts = 0;
  bit  inFrame = 0;

  always @(negedge clk) begin
    if (csN) begin
      inFrame = 0;
      ioIn = 4'h0;
    end else begin
      if (!inFrame) begin
        inFrame = 1;
        capCnt = 0;
        frameStarts++;
      end
      if (sck) begin
        if (capCnt < 128) begin
          capOut[capCnt] = ioOut;
          capOe[capCnt]  = ioOe;
        end
        capCnt++;
      end else begin
        ioIn = (capCnt < 128) ? supply[capCnt] : 4'h0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lw(input logic [1:0] code);
    return (code == 2'b01) ? 2 : (code == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [3:0] oePat(input int w);
    return (w == 4) ? 4'hF : (w == 2) ? 4'h3 : 4'h1;
  endfunction

  function automatic logic [31:0] gather(input int start, input int n, input int w);
    logic [31:0] v = 0;
    for (int j = 0; j < n; j++) v = (v << w) | 32'(capOut[start + j] & oePat(w));
    return v;
  endfunction

  task automatic setSupply(input int start, input int w, input logic [31:0] word);
    for (int j = 0; j < 128; j++) supply[j] = 4'h0;
    for (int j = 0; j < 32 / w; j++) begin
      logic [3:0] chunk;
      chunk = 4'((word >> (32 - w * (j + 1))) & 32'(oePat(w)));
      supply[start + j] = (w == 1) ? {2'b00, chunk[0], 1'b0} : chunk;
    end
  endtask

  // OR of ioOe over a range of serial clocks
  function automatic logic [3:0] oeOr(input int start, input int n);
    logic [3:0] v = 0;
    for (int j = 0; j < n; j++) v |= capOe[start + j];
    return v;
  endfunction

  task automatic clearCfg();
    cfgMemMode = 0; cfgInstEn = 0; cfgAddrEn = 0; cfgAddr32 = 0; cfgOptEn = 0;
    cfgDataEn = 0; cfgDataRead = 0; cfgContRead = 0; cfgDummy = 0;
    cfgInstLanes = 0; cfgAddrLanes = 0; cfgDataLanes = 0;
  endtask

  task automatic pulseCmd();
    @(negedge clk) cmdStart = 1;
    @(negedge clk) cmdStart = 0;
  endtask

  task automatic pulseRd(input logic [WIN_AW-1:0] a);
    @(negedge clk) begin rdReq = 1; rdAddr = a; end
    @(negedge clk) rdReq = 0;
  endtask

  task automatic waitDone(input string req, output bit seenValid);
    seenValid = 0;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (frameDone) begin
        seenValid = rdValid;
        return;
      end
    end
    chk(req, "frame never ended", 0, 1);
  endtask

  task automatic testReset();
    chk("R1", "csN after reset", 32'(csN), 1);
    chk("R1", "sck after reset", 32'(sck), 0);
    chk("R1", "ioOe after reset", 32'(ioOe), 0);
    chk("R1", "busy after reset", 32'(busy), 0);
    chk("R8", "rdValid after reset", 32'(rdValid), 0);
  endtask

  task automatic testSingleIdRead();
    bit v;
    clearCfg();
    cfgInstEn = 1; cfgOpcode = 8'h9F; cfgDataEn = 1; cfgDataRead = 1;
    setSupply(8, 1, 32'hC2201A5F);
    pulseCmd();
    waitDone("R6", v);
    chk("R11", "clock count single read", capCnt, 40);
    chk("R2", "opcode single lane", gather(0, 8, 1), 32'h9F);
    chk("R7", "single lane oe", 32'(oeOr(0, 8)), 32'h1);
    chk("R6", "oe during read data", 32'(oeOr(8, 32)), 0);
    chk("R6", "single read word on IO1", rdData, 32'hC2201A5F);
    chk("R9", "no rdValid for command frame", 32'(v), 0);
  endtask

  task automatic testQuadFastRead();
    bit v;
    clearCfg();
    cfgInstEn = 1; cfgOpcode = 8'hEB; cfgAddrEn = 1; cfgAddrLanes = 2'b10;
    cfgOptEn = 1; cfgOptByte = 8'hA5; cfgDummy = 4;
    cfgDataEn = 1; cfgDataRead = 1; cfgDataLanes = 2'b10;
    cmdAddr = 32'hAB123456;
    setSupply(20, 4, 32'h89ABCDEF);
    pulseCmd();
    waitDone("R3", v);
    chk("R11", "clock count quad read", capCnt, 28);
    chk("R2", "opcode", gather(0, 8, 1), 32'hEB);
    chk("R3", "24-bit quad address", gather(8, 6, 4), 32'h123456);
    chk("R7", "quad address oe", 32'(capOe[8]), 32'hF);
    chk("R4", "mode byte quad", gather(14, 2, 4), 32'hA5);
    chk("R5", "oe during dummy", 32'(oeOr(16, 4)), 0);
    chk("R6", "quad read word", rdData, 32'h89ABCDEF);
  endtask

  task automatic testDualWrite32();
    bit v;
    clearCfg();
    cfgInstEn = 1; cfgInstLanes = 2'b01; cfgOpcode = 8'h12;
    cfgAddrEn = 1; cfgAddrLanes = 2'b01; cfgAddr32 = 1;
    cfgDataEn = 1; cfgDataRead = 0; cfgDataLanes = 2'b01;
    cmdAddr = 32'h89ABCDEF; cmdWrData = 32'h3C5AA55C;
    pulseCmd();
    waitDone("R6", v);
    chk("R11", "clock count dual write", capCnt, 36);
    chk("R2", "opcode dual", gather(0, 4, 2), 32'h12);
    chk("R3", "32-bit dual address", gather(4, 16, 2), 32'h89ABCDEF);
    chk("R6", "dual write word", gather(20, 16, 2), 32'h3C5AA55C);
    chk("R7", "dual oe", 32'(capOe[20]), 32'h3);
  endtask

  task automatic testReservedLane();
    bit v;
    clearCfg();
    cfgInstEn = 1; cfgInstLanes = 2'b11; cfgOpcode = 8'h06;
    pulseCmd();
    waitDone("R7", v);
    chk("R11", "opcode-only frame clocks", capCnt, 8);
    chk("R7", "reserved lane code acts single", gather(0, 8, 1), 32'h06);
    chk("R7", "reserved lane oe", 32'(oeOr(0, 8)), 32'h1);
    chk("R13", "csN high after frame", 32'(csN), 1);
    chk("R13", "sck low after frame", 32'(sck), 0);
  endtask

  task automatic testDummyMax();
    bit v;
    clearCfg();
    cfgInstEn = 1; cfgOpcode = 8'h0B; cfgAddrEn = 1; cfgDummy = 15;
    cfgDataEn = 1; cfgDataRead = 1;
    cmdAddr = 32'h0000ABCD;
    setSupply(47, 1, 32'h5A5AF00F);
    pulseCmd();
    waitDone("R5", v);
    chk("R5", "clock count with 15 dummies", capCnt, 79);
    chk("R3", "single 24-bit address", gather(8, 24, 1), 32'h00ABCD);
    chk("R5", "oe during 15 dummies", 32'(oeOr(32, 15)), 0);
    chk("R6", "read word after dummies", rdData, 32'h5A5AF00F);
  endtask

  task automatic testMemRead();
    bit v;
    clearCfg();
    cfgMemMode = 1; cfgInstEn = 1; cfgOpcode = 8'h0C; cfgAddr32 = 1;
    cfgAddrLanes = 2'b10; cfgDummy = 2; cfgDataLanes = 2'b10;
    cmdAddr = 32'h11111111;
    setSupply(18, 4, 32'hDEADBEEF);
    pulseRd(26'h2ABCDEF);
    waitDone("R8", v);
    chk("R8", "memory read clocks", capCnt, 26);
    chk("R8", "window offset as address", gather(8, 8, 4), 32'h02ABCDEF);
    chk("R8", "rdValid with frameDone", 32'(v), 1);
    chk("R8", "memory read word", rdData, 32'hDEADBEEF);
    @(negedge clk);
    chk("R8", "rdValid one cycle", 32'(rdValid), 0);
  endtask

  task automatic testContinuous();
    bit v;
    clearCfg();
    cfgMemMode = 1; cfgContRead = 1; cfgInstEn = 1; cfgOpcode = 8'hEB;
    cfgAddrLanes = 2'b10; cfgOptEn = 1; cfgOptByte = 8'h20; cfgDummy = 4;
    cfgDataLanes = 2'b10;
    setSupply(20, 4, 32'h01234567);
    pulseRd(26'h0000040);
    waitDone("R10", v);
    chk("R10", "first read has opcode", capCnt, 28);
    chk("R10", "first read opcode", gather(0, 8, 1), 32'hEB);
    setSupply(12, 4, 32'h76543210);
    pulseRd(26'h0000100);
    waitDone("R10", v);
    chk("R10", "second read skips opcode", capCnt, 20);
    chk("R10", "second read address first", gather(0, 6, 4), 32'h000100);
    chk("R10", "second read word", rdData, 32'h76543210);
    @(negedge clk) cfgContRead = 0;
    setSupply(20, 4, 32'hCAFEF00D);
    pulseRd(26'h0000200);
    waitDone("R10", v);
    chk("R10", "opcode back after clearing", capCnt, 28);
    chk("R10", "opcode back value", gather(0, 8, 1), 32'hEB);
  endtask

  task automatic testIgnored();
    int startsBefore;
    bit anyValid = 0;
    clearCfg();
    cfgInstEn = 1; cfgOpcode = 8'h06;
    startsBefore = frameStarts;
    cfgMemMode = 1;
    pulseCmd();
    repeat (20) @(negedge clk) anyValid |= rdValid;
    chk("R9", "cmdStart in memory mode", frameStarts - startsBefore, 0);
    cfgMemMode = 0;
    pulseRd(26'h0000010);
    repeat (20) @(negedge clk) anyValid |= rdValid;
    chk("R9", "rdReq in command mode", frameStarts - startsBefore, 0);
    chk("R9", "no rdValid from ignored requests", 32'(anyValid), 0);
    chk("R1", "idle csN after ignored requests", 32'(csN), 1);
  endtask

  task automatic testBusyIgnore();
    bit v;
    int startsBefore;
    clearCfg();
    cfgInstEn = 1; cfgOpcode = 8'h06;
    startsBefore = frameStarts;
    pulseCmd();
    repeat (3) @(negedge clk);
    chk("R12", "busy during frame", 32'(busy), 1);
    pulseCmd();
    waitDone("R12", v);
    repeat (20) @(negedge clk);
    chk("R12", "request while busy dropped", frameStarts - startsBefore, 1);
    chk("R12", "clock count unchanged", capCnt, 8);
    chk("R13", "csN high between frames", 32'(csN), 1);
  endtask

  initial begin
    for (int j = 0; j < 128; j++) begin
      supply[j] = 4'h0; capOut[j] = 4'h0; capOe[j] = 4'h0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSingleIdRead();
    testQuadFastRead();
    testDualWrite32();
    testReservedLane();
    testDummyMax();
    testMemRead();
    testContinuous();
    testIgnored();
    testBusyIgnore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule